// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Engine

This block sits on the flash side of a memory interface and serves reads from a small internal word array. Its behaviour is set by an 8-bit read configuration word. Software delivers that word through a three-write command sequence in which the value rides in the command address. After reset the block answers plain asynchronous reads: the word at the presented address comes back one clock later.

When the configuration selects synchronous mode, a read begins while the address-valid strobe `avd_n` is low. On each such edge the engine loads the start address. Once the strobe is released, the engine counts a programmed number of clock edges and then streams consecutive words, one per clock. The stream either runs straight through the array or wraps inside an aligned 8, 16 or 32 word block. A ready output rises either together with the first word or one clock before it. The data output can change on the rising clock edge, or half a cycle later on the falling edge.

Top module: `burst_rd_engine`

## Requirements
- R1: While `rst` is high, `rd_rdy` is 0 and `rd_data` is 0. After reset the configuration is 0xA0: asynchronous reads, rising-edge launch, linear order, wait code 0.
- R2: A configuration update is three consecutive `cmd_we` writes: data 0xAA at offset 0x555, then 0x55 at offset 0x2AA, then 0xC0 at offset 0x555. The offset is `cmd_addr[11:0]`. The new configuration value is `cmd_addr[19:12]` of the third write and takes effect from the next clock edge. Any write that breaks the sequence returns it to its start and changes nothing.
- R3: If `op_busy` is high during the third write, the configuration keeps its previous value.
- R4: A configuration value whose bits [2:0] are 6 or 7 is discarded, and the previous configuration stays in force.
- R5: With configuration bit 7 = 1 (asynchronous), each clock edge samples `rd_addr` = a, and `rd_rdy` = 1. With default parameters, array word a is {a,a} XOR 0xA5C3.
- R6: With bit 7 = 0 (synchronous), every edge that samples `avd_n` low loads `rd_addr` as the start address and clears `rd_data` and `rd_rdy`. The first later edge that samples `avd_n` high counts as edge 1. The first word appears at edge (bits[2:0] + 2). Before the first word, and in synchronous mode before any strobe, `rd_data` is 0.
- R7: Bit 6 = 1 raises `rd_rdy` at the edge that delivers the first word. Bit 6 = 0 raises it one edge earlier. It then stays high for the whole burst.
- R8: Bits [4:3] = 0 give a linear burst: each edge delivers the next address, and the address rolls from the last array word to word 0.
- R9: Bits [4:3] = 1, 2 or 3 wrap the burst inside the aligned 8, 16 or 32 word block that holds the start address. Only the low 3, 4 or 5 address bits increment.
- R10: Bit 5 = 1 makes `rd_data` change on the rising clock edge. Bit 5 = 0 delays every change to the next falling edge. `rd_rdy` always changes on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_we | input | 1 | Command write strobe |
| cmd_addr | input | 20 | Command address; bits [11:0] offset, bits [19:12] configuration value |
| cmd_data | input | 8 | Command data byte |
| op_busy | input | 1 | High while a program, erase or lock operation runs |
| avd_n | input | 1 | Address-valid strobe, active low |
| rd_addr | input | 8 | Read or burst start address |
| rd_data | output | 16 | Read data word |
| rd_rdy | output | 1 | Data ready indication |

## Verification
A corrupted configuration register shows up at once: within one clock the ready line stops tracking the selected mode, or the data moves on the wrong clock edge. A wrong wait counter shifts the first word and the ready edge by whole cycles from the strobe release, so it appears within eight cycles. A broken address increment leaves or misses an aligned block. That is visible on the first crossing of a block boundary, so bursts start near block ends and near the array end, and every output is compared at both clock phases on every cycle.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [1:0] {
        BM_LINEAR = 2'd0,
        BM_WRAP8  = 2'd1,
        BM_WRAP16 = 2'd2,
        BM_WRAP32 = 2'd3
    } burst_mode_e;

    // bit 7 .. bit 0 of the configuration value
    typedef struct packed {
        logic        async_rd;
        logic        rdy_with_data;
        logic        rise_launch;
        burst_mode_e mode;
        logic [2:0]  wait_code;
    } rd_cfg_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_WAIT  = 2'd1,
        SQ_BURST = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        UL_IDLE   = 2'd0,
        UL_FIRST  = 2'd1,
        UL_SECOND = 2'd2
    } unlock_e;

    localparam rd_cfg_t CFG_RESET     = rd_cfg_t'(8'hA0);
    localparam int      UL_OFS_A      = 'h555;
    localparam int      UL_OFS_B      = 'h2AA;
    localparam logic [7:0] UL_BYTE_A  = 8'hAA;
    localparam logic [7:0] UL_BYTE_B  = 8'h55;
    localparam logic [7:0] CMD_SETCFG = 8'hC0;
    localparam logic [2:0] WAIT_MAX   = 3'd5;

    // number of low address bits that step inside a wrap block
    function automatic int wrap_bits(burst_mode_e m);
        case (m)
            BM_WRAP8:  return 3;
            BM_WRAP16: return 4;
            BM_WRAP32: return 5;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/brc_cfg_reg.sv
module brc_cfg_reg
    import brc_pkg::*;
#(
    parameter int CFG_LSB = 12,
    localparam int CMD_AW = CFG_LSB + 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              op_busy,
    output rd_cfg_t           cfg
);
    logic [CFG_LSB-1:0] ofs;
    rd_cfg_t            req;
    unlock_e            stage;
    logic               hit_a, hit_b, hit_set, take;

    assign ofs     = cmd_addr[CFG_LSB-1:0];
    assign req     = rd_cfg_t'(cmd_addr[CFG_LSB +: 8]);
    assign hit_a   = (ofs == CFG_LSB'(UL_OFS_A)) && (cmd_data == UL_BYTE_A);
    assign hit_b   = (ofs == CFG_LSB'(UL_OFS_B)) && (cmd_data == UL_BYTE_B);
    assign hit_set = (ofs == CFG_LSB'(UL_OFS_A)) && (cmd_data == CMD_SETCFG);
    assign take    = (stage == UL_SECOND) && hit_set && !op_busy
                     && (req.wait_code <= WAIT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= UL_IDLE;
            cfg   <= CFG_RESET;
        end else if (cmd_we) begin
            case (stage)
                UL_IDLE:  stage <= hit_a ? UL_FIRST  : UL_IDLE;
                UL_FIRST: stage <= hit_b ? UL_SECOND : UL_IDLE;
                default:  stage <= UL_IDLE;
            endcase
            if (take) cfg <= req;
        end
    end
endmodule

// File: rtl/brc_word_rom.sv
module brc_word_rom #(
    parameter int AW   = 8,
    parameter int DW   = 16,
    parameter int SEED = 'hA5C3,
    localparam int DEPTH = 1 << AW
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] word
);
    logic [DW-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign words[i] = DW'(i * 257) ^ DW'(SEED);
    end

    assign word = words[addr];
endmodule

// File: rtl/brc_burst_seq.sv
module brc_burst_seq
    import brc_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    localparam int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          async_rd,
    input  logic          rdy_with_data,
    input  burst_mode_e   mode,
    input  logic [2:0]    wait_code,
    input  logic          avd_n,
    input  logic [AW-1:0] rd_addr,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_word,
    output seq_state_e    st,
    output logic [AW-1:0] cur,
    output logic [DW-1:0] q,
    output logic          rdy
);
    logic [CW-1:0] cnt, cnt_nx, first_edge;
    logic [AW-1:0] step, low_mask, nxt;

    assign first_edge = CW'(wait_code) + CW'(2);
    assign cnt_nx     = cnt + CW'(1);
    assign step       = cur + AW'(1);
    assign low_mask   = AW'((1 << wrap_bits(mode)) - 1);
    assign nxt        = (mode == BM_LINEAR) ? step
                        : ((cur & ~low_mask) | (step & low_mask));
    assign mem_addr   = async_rd ? rd_addr : cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SQ_IDLE;
            cur <= '0;
            cnt <= '0;
            q   <= '0;
            rdy <= 1'b0;
        end else if (async_rd) begin
            st  <= SQ_IDLE;
            cnt <= '0;
            q   <= mem_word;
            rdy <= 1'b1;
        end else if (!avd_n) begin
            st  <= SQ_WAIT;
            cur <= rd_addr;
            cnt <= '0;
            q   <= '0;
            rdy <= 1'b0;
        end else begin
            case (st)
                SQ_WAIT: begin
                    if (cnt_nx >= first_edge) begin
                        st  <= SQ_BURST;
                        q   <= mem_word;
                        cur <= nxt;
                        rdy <= 1'b1;
                    end else begin
                        cnt <= cnt_nx;
                        rdy <= !rdy_with_data && (cnt_nx >= first_edge - CW'(1));
                    end
                end
                SQ_BURST: begin
                    q   <= mem_word;
                    cur <= nxt;
                    rdy <= 1'b1;
                end
                default: begin
                    q   <= '0;
                    rdy <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/burst_rd_engine.sv
module burst_rd_engine
    import brc_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 16,
    parameter int CFG_LSB = 12,
    parameter int SEED    = 'hA5C3,
    localparam int CMD_AW = CFG_LSB + 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              op_busy,
    input  logic              avd_n,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              rd_rdy
);
    rd_cfg_t       cfg;
    seq_state_e    seq_st;
    logic [AW-1:0] cur_addr, mem_addr;
    logic [DW-1:0] mem_word, q_rise, q_fall;

    brc_cfg_reg #(.CFG_LSB(CFG_LSB)) u_cfg (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .op_busy(op_busy), .cfg(cfg)
    );

    brc_word_rom #(.AW(AW), .DW(DW), .SEED(SEED)) u_rom (
        .addr(mem_addr), .word(mem_word)
    );

    brc_burst_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst(rst),
        .async_rd(cfg.async_rd), .rdy_with_data(cfg.rdy_with_data),
        .mode(cfg.mode), .wait_code(cfg.wait_code),
        .avd_n(avd_n), .rd_addr(rd_addr),
        .mem_addr(mem_addr), .mem_word(mem_word),
        .st(seq_st), .cur(cur_addr), .q(q_rise), .rdy(rd_rdy)
    );

    // half-cycle delayed copy for falling-edge launch
    always_ff @(negedge clk) begin
        if (rst) q_fall <= '0;
        else     q_fall <= q_rise;
    end

    assign rd_data = cfg.rise_launch ? q_rise : q_fall;
endmodule

// File: rtl/brc_chk.sv
module brc_chk
    import brc_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          op_busy,
    input logic          avd_n,
    input logic          rd_rdy,
    input rd_cfg_t       cfg,
    input seq_state_e    seq_st,
    input logic [AW-1:0] cur_addr
);
    // R3: configuration frozen across a busy cycle
    a_r3_busy_holds_cfg: assert property (@(posedge clk) disable iff (rst)
        op_busy |=> $stable(cfg));

    // R4: reserved wait codes never reach the register
    a_r4_no_reserved_wait: assert property (@(posedge clk) disable iff (rst)
        cfg.wait_code < 3'd6);

    // R5: asynchronous mode keeps ready high
    a_r5_async_ready: assert property (@(posedge clk) disable iff (rst)
        cfg.async_rd |=> rd_rdy);

    // R6: address phase never signals ready
    a_r6_addr_phase_quiet: assert property (@(posedge clk) disable iff (rst)
        (!cfg.async_rd && !avd_n) |=> !rd_rdy);

    // R8: linear burst steps by one
    a_r8_linear_step: assert property (@(posedge clk) disable iff (rst)
        (seq_st == SQ_BURST && avd_n && !cfg.async_rd && cfg.mode == BM_LINEAR)
        |=> cur_addr == AW'($past(cur_addr) + 1'b1));

    // R9: wrap burst stays inside its aligned block
    a_r9_block_kept: assert property (@(posedge clk) disable iff (rst)
        (seq_st == SQ_BURST && avd_n && !cfg.async_rd && cfg.mode != BM_LINEAR)
        |=> cur_addr[AW-1:5] == $past(cur_addr[AW-1:5]));
endmodule

bind burst_rd_engine brc_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .op_busy(op_busy), .avd_n(avd_n),
    .rd_rdy(rd_rdy), .cfg(cfg), .seq_st(seq_st), .cur_addr(cur_addr)
);

// File: tb/sim_burst_rd_engine.sv
`timescale 1ns/1ps
module sim_burst_rd_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_we = 1'b0;
    logic [19:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic        op_busy = 1'b0;
    logic        avd_n = 1'b1;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        rd_rdy;

    int    tests = 0;
    int    fails = 0;
    string phase = "R1 reset";
    bit    done = 1'b0;

    burst_rd_engine u0 (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .op_busy(op_busy), .avd_n(avd_n),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_rdy(rd_rdy)
    );

    always #4 clk = ~clk;   // 125 MHz

    // ---------------- behavioural reference ----------------
    int          m_cfg = 8'hA0, m_stage = 0, m_st = 0, m_cnt = 0, m_cur = 0;
    logic [15:0] m_q = '0, m_qold = '0;
    logic        m_rdy = 1'b0;

    function automatic logic [15:0] pat(int a);
        logic [7:0] b = a[7:0];
        return {b, b} ^ 16'hA5C3;
    endfunction

    function automatic int adv(int a, int mode);
        int span = (mode == 0) ? 8 : mode + 2;
        int msk  = (1 << span) - 1;
        return ((a & ~msk) | ((a + 1) & msk)) & 255;
    endfunction

    always @(posedge clk) begin
        int lo, val, need;
        m_qold = m_q;
        if (rst) begin
            m_cfg = 8'hA0; m_stage = 0; m_st = 0; m_cnt = 0; m_cur = 0;
            m_q = '0; m_rdy = 1'b0;
        end else begin
            if (m_cfg[7]) begin
                m_q = pat(rd_addr); m_rdy = 1'b1; m_st = 0; m_cnt = 0;
            end else if (!avd_n) begin
                m_st = 1; m_cur = rd_addr; m_cnt = 0; m_q = '0; m_rdy = 1'b0;
            end else if (m_st == 0) begin
                m_q = '0; m_rdy = 1'b0;
            end else if (m_st == 1) begin
                need = (m_cfg & 7) + 2;
                m_cnt++;
                if (m_cnt >= need) begin
                    m_q = pat(m_cur); m_cur = adv(m_cur, (m_cfg >> 3) & 3);
                    m_st = 2; m_rdy = 1'b1;
                end else begin
                    m_rdy = !m_cfg[6] && (m_cnt >= need - 1);
                end
            end else begin
                m_q = pat(m_cur); m_cur = adv(m_cur, (m_cfg >> 3) & 3);
                m_rdy = 1'b1;
            end
            if (cmd_we) begin
                lo  = cmd_addr[11:0];
                val = cmd_addr[19:12];
                if (m_stage == 0)
                    m_stage = (lo == 'h555 && cmd_data == 8'hAA) ? 1 : 0;
                else if (m_stage == 1)
                    m_stage = (lo == 'h2AA && cmd_data == 8'h55) ? 2 : 0;
                else begin
                    if (lo == 'h555 && cmd_data == 8'hC0 && !op_busy && (val & 7) < 6)
                        m_cfg = val;
                    m_stage = 0;
                end
            end
        end
    end

    task automatic check(string when, logic [15:0] exp_d, logic exp_r);
        tests++;
        if (rd_data !== exp_d || rd_rdy !== exp_r) begin
            fails++;
            $display("FAIL %s (%s) t=%0t: data=%h rdy=%b expected data=%h rdy=%b",
                     phase, when, $time, rd_data, rd_rdy, exp_d, exp_r);
        end
    endtask

    // compare after the rising edge (R10 edge check) and after the falling edge
    always @(posedge clk) begin
        #2;
        if (!done) check("after rise", m_cfg[5] ? m_q : m_qold, m_rdy);
        #4;
        if (!done) check("after fall", m_q, m_rdy);
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk); #3;
    endtask

    task automatic wr(logic [19:0] a, logic [7:0] d, logic busy);
        cmd_we = 1'b1; cmd_addr = a; cmd_data = d; op_busy = busy;
        tick();
        cmd_we = 1'b0; op_busy = 1'b0;
    endtask

    task automatic set_cfg(logic [7:0] v, logic busy);
        wr(20'h00555, 8'hAA, 1'b0);
        wr(20'h002AA, 8'h55, 1'b0);
        wr({v, 12'h555}, 8'hC0, busy);
        tick();
    endtask

    task automatic burst(logic [7:0] start, int len);
        avd_n = 1'b0; rd_addr = start;
        tick();
        avd_n = 1'b1; rd_addr = 8'h00;
        repeat (len) tick();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        done = 1'b1;
        fails++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R1 reset
        repeat (4) tick();
        rst = 1'b0;
        // R5 asynchronous reads with address pattern
        phase = "R5 async";
        for (int i = 0; i < 8; i++) begin
            rd_addr = 8'(i * 37 + 3);
            tick();
        end
        // R2 broken sequence must not update
        phase = "R2 abort";
        wr(20'h00555, 8'hAA, 1'b0);
        wr(20'h00000, 8'h12, 1'b0);
        wr({8'h61, 12'h555}, 8'hC0, 1'b0);
        repeat (3) begin rd_addr = rd_addr + 8'd9; tick(); end
        // R3 busy blocks update
        phase = "R3 busy";
        set_cfg(8'h61, 1'b1);
        repeat (3) begin rd_addr = rd_addr + 8'd5; tick(); end
        // R4 reserved wait code ignored
        phase = "R4 reserved";
        set_cfg(8'h66, 1'b0);
        set_cfg(8'h67, 1'b0);
        repeat (3) begin rd_addr = rd_addr + 8'd3; tick(); end
        // R2 valid write: synchronous, idle output zero
        phase = "R2 sync set";
        set_cfg(8'h61, 1'b0);
        repeat (3) tick();
        // R8 linear across array end
        phase = "R8 linear";
        burst(8'hFB, 14);
        // R6 every wait code, ready with data
        for (int c = 0; c < 6; c++) begin
            phase = "R6 wait";
            set_cfg(8'(8'h60 | c), 1'b0);
            burst(8'(16 * c + 7), 11);
        end
        // R7 ready one cycle early
        for (int c = 0; c < 6; c += 2) begin
            phase = "R7 early ready";
            set_cfg(8'(8'h20 | c), 1'b0);
            burst(8'(8'h40 + c), 10);
        end
        // R9 wrap modes
        for (int m = 1; m < 4; m++) begin
            phase = "R9 wrap";
            set_cfg(8'(8'h60 | (m << 3) | 1), 1'b0);
            burst(8'h35, 40);
            burst(8'hFE, 36);
        end
        // R10 falling-edge launch
        phase = "R10 falling";
        set_cfg(8'h4A, 1'b0);
        burst(8'h9C, 20);
        set_cfg(8'h03, 1'b0);
        burst(8'h21, 14);
        phase = "R10 falling async";
        set_cfg(8'h80, 1'b0);
        for (int i = 0; i < 6; i++) begin rd_addr = 8'(i * 11); tick(); end
        // R1 reset during a burst
        phase = "R1 mid reset";
        set_cfg(8'h70, 1'b0);
        avd_n = 1'b0; rd_addr = 8'h10; tick(); avd_n = 1'b1;
        repeat (5) tick();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        phase = "R1 after reset";
        repeat (4) begin rd_addr = rd_addr + 8'd1; tick(); end
        done = 1'b1;
        #1;
        summary();
        $finish;
    end
endmodule